// File: doc/BRIEF.md
# Programmable GPIO Port Bank

A bank of byte-wide general-purpose I/O ports behind a small synchronous register bus. Each port has its own direction register, where a 1 makes a pin an output, and a data register. Writing the data register loads an output latch. Reading it returns, bit by bit, either the latch (output pins) or the synchronized pin level (input pins). Pull-up enables are grouped per four adjacent pins and are held in shared pull-up control bytes. The highest-numbered ports need an extra global enable bit before their pull-ups take effect.

An external-bus mode input marks a fixed set of ports as borrowed by an external memory bus. While the mode is high, writes to those ports' direction bits are dropped and their pull-ups are held off. Their pull-up control bits still accept writes and read back normally. A control bit forces every read of one chosen port to return its latch. One pin has no direction bit and is always an input.

Pin inputs pass through a two-flop synchronizer, so a pin read shows the level from two clocks earlier. The bus is combinational on reads and takes writes on the clock edge where select and write are both high.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every direction bit, output latch, pull-up control bit and the latch-read control bit read 0, so pin_oe, pin_out and pin_pu are all 0.
- R2: A write to address 0x00+p sets port p's direction byte, which reads back at the same address. pin_oe of each bit equals its direction bit (1 = output).
- R3: A read of address 0x10+p returns, per bit, the output latch for output bits and, for input bits, the pin level sampled at least two clocks before the read.
- R4: A write to 0x10+p always loads port p's latch, whatever the direction. pin_out shows the latch only on output bits and is 0 on input bits.
- R5: Pull-up register k (address 0x20+k), bit j, enables nibble n = 8k+j. Nibble n covers port n/2, bits 0-3 when n is even and bits 4-7 when n is odd. pin_pu is 1 only on input pins of an enabled nibble.
- R6: Ports numbered 5 and up get pull-ups only while bit 7 of the last pull-up register (address 0x21) is 1.
- R7: While bus_ext_mode is 1, writes to the direction registers of ports 0, 1 and 2 leave them unchanged. Other ports' direction registers still take writes.
- R8: While bus_ext_mode is 1, pin_pu is 0 on ports 0 to 2. Their pull-up control bits can still be written and read back.
- R9: When bit 0 of the control register at 0x30 is 1, reads of port 1's data register return its latch on all bits. Other ports are unaffected.
- R10: Port 4 bit 5 has no direction bit. It reads 0 at address 0x04, and its pin_oe is always 0.
- R11: Reads of unmapped addresses return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address: high nibble selects the register space, low nibble the index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when no read is selected |
| bus_ext_mode | input | 1 | External-bus mode active |
| pin_in | input | 48 | Pin input levels, port p on bits 8p+7..8p |
| pin_oe | output | 48 | Pin output enables |
| pin_out | output | 48 | Pin output data |
| pin_pu | output | 48 | Pin pull-up enables |

## Verification
The hardest case to reach is the interaction between the external-bus mode and state set up before it was raised. The pull-up bits and direction bits of the borrowed ports must already be non-zero so that a blocked write and a suppressed pull-up differ visibly from reset. The stimulus first programs direction, latch and pull-up values on shared and unshared ports with the mode low, then raises the mode. It writes new values to both kinds of port and reads them back. After lowering the mode, it checks that the pull-ups return according to the rewritten control bits and the current directions. A per-clock reference model covers the two-clock pin-read lag and the latch-read override throughout.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = 4;
  localparam int ADDR_W = 8;

  localparam logic [3:0] PG_DIR  = 4'h0;
  localparam logic [3:0] PG_DATA = 4'h1;
  localparam logic [3:0] PG_PULL = 4'h2;
  localparam logic [3:0] PG_CTRL = 4'h3;

  typedef struct packed {
    logic              wr;
    logic              rd;
    logic [3:0]        page;
    logic [3:0]        idx;
    logic [DATA_W-1:0] wdata;
  } bus_req_t;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_ni = stage2_q;
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W        = 8,
  parameter bit HAS_HOLE = 1'b0,
  parameter int HOLE_BIT = 0,
  parameter bit LOCKABLE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         dir_we,
  input  logic         lat_we,
  input  logic [W-1:0] wdata,
  input  logic         bus_mode,
  input  logic         force_latch,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] lat_q,
  output logic [W-1:0] rd_value
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] IMPL = HAS_HOLE ? ~(ONE << HOLE_BIT) : {W{1'b1}};

  logic [W-1:0] dir_d, lat_d, latch_sel;
  logic         dir_lock;

  assign dir_lock = LOCKABLE && bus_mode;

  always_comb begin
    dir_d = dir_q;
    lat_d = lat_q;
    if (dir_we && !dir_lock) dir_d = wdata & IMPL;
    if (lat_we)              lat_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      lat_q <= '0;
    end else begin
      dir_q <= dir_d;
      lat_q <= lat_d;
    end
  end

  assign latch_sel = dir_q | {W{force_latch}};
  assign rd_value  = (lat_q & latch_sel) | (pin_sync & ~latch_sel);
endmodule

// File: rtl/gpio_pullup.sv
module gpio_pullup
  import gpio_pkg::*;
#(
  parameter int                 NUM_PORTS  = 6,
  parameter int                 NPU        = 2,
  parameter int                 GATED_FROM = 5,
  parameter logic [NUM_PORTS-1:0] BUS_MASK = '0
) (
  input  logic                        clk,
  input  logic                        rst_ni,
  input  logic                        we,
  input  logic [3:0]                  idx,
  input  logic [DATA_W-1:0]           wdata,
  input  logic                        bus_mode,
  input  logic [NUM_PORTS*DATA_W-1:0] dir_all,
  output logic [DATA_W-1:0]           rd_value,
  output logic [NUM_PORTS*DATA_W-1:0] pin_pu
);
  localparam int NIB_PER_PORT = DATA_W / NIB_W;
  localparam int NNIB         = NUM_PORTS * NIB_PER_PORT;

  logic [NNIB-1:0] nib_q, nib_d, nib_act;
  logic            glob_q, glob_d;

  always_comb begin
    nib_d  = nib_q;
    glob_d = glob_q;
    if (we && (int'(idx) < NPU)) begin
      for (int j = 0; j < DATA_W; j++) begin
        if ((int'(idx) == NPU - 1) && (j == DATA_W - 1))
          glob_d = wdata[j];
        else if (int'(idx) * DATA_W + j < NNIB)
          nib_d[int'(idx) * DATA_W + j] = wdata[j];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      nib_q  <= '0;
      glob_q <= 1'b0;
    end else begin
      nib_q  <= nib_d;
      glob_q <= glob_d;
    end
  end

  always_comb begin
    rd_value = '0;
    if (int'(idx) < NPU) begin
      for (int j = 0; j < DATA_W; j++) begin
        if ((int'(idx) == NPU - 1) && (j == DATA_W - 1))
          rd_value[j] = glob_q;
        else if (int'(idx) * DATA_W + j < NNIB)
          rd_value[j] = nib_q[int'(idx) * DATA_W + j];
      end
    end
  end

  for (genvar n = 0; n < NNIB; n++) begin : g_nib
    localparam int PORT = n / NIB_PER_PORT;
    localparam bit SHARED = BUS_MASK[PORT];
    localparam bit GATED  = (PORT >= GATED_FROM);
    logic bus_block, gate_ok;
    assign bus_block  = SHARED && bus_mode;
    assign gate_ok    = !GATED || glob_q;
    assign nib_act[n] = nib_q[n] && !bus_block && gate_ok;
    for (genvar b = 0; b < NIB_W; b++) begin : g_bit
      assign pin_pu[n*NIB_W + b] = nib_act[n] && !dir_all[n*NIB_W + b];
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int                   NUM_PORTS  = 6,
  parameter logic [NUM_PORTS-1:0] BUS_MASK   = 6'b000111,
  parameter int                   GATED_FROM = 5,
  parameter int                   NODIR_PORT = 4,
  parameter int                   NODIR_BIT  = 5,
  parameter int                   LATCH_PORT = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_sel,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  input  logic                        bus_ext_mode,
  input  logic [NUM_PORTS*DATA_W-1:0] pin_in,
  output logic [NUM_PORTS*DATA_W-1:0] pin_oe,
  output logic [NUM_PORTS*DATA_W-1:0] pin_out,
  output logic [NUM_PORTS*DATA_W-1:0] pin_pu
);
  localparam int NPU  = (NUM_PORTS * DATA_W / NIB_W) / DATA_W + 1;
  localparam int PW   = NUM_PORTS * DATA_W;

  logic     rst_ni;
  bus_req_t req;
  logic [PW-1:0]     pin_sync, dir_all, lat_all, rd_all;
  logic [DATA_W-1:0] pull_rd, sel_rd;
  logic              pcr_q, pcr_d, pcr_we, pull_we;

  gpio_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .rst_ni(rst_ni));

  gpio_sync2 #(.W(PW)) i_sync (
    .clk(clk), .rst_ni(rst_ni), .d(pin_in), .q(pin_sync)
  );

  always_comb begin
    req.wr    = bus_sel && bus_wr;
    req.rd    = bus_sel && !bus_wr;
    req.page  = bus_addr[7:4];
    req.idx   = bus_addr[3:0];
    req.wdata = bus_wdata;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic dir_we, lat_we;
    assign dir_we = req.wr && (req.page == PG_DIR)  && (req.idx == 4'(p));
    assign lat_we = req.wr && (req.page == PG_DATA) && (req.idx == 4'(p));
    gpio_port #(
      .W(DATA_W),
      .HAS_HOLE(p == NODIR_PORT),
      .HOLE_BIT(NODIR_BIT),
      .LOCKABLE(BUS_MASK[p])
    ) i_port (
      .clk(clk),
      .rst_ni(rst_ni),
      .dir_we(dir_we),
      .lat_we(lat_we),
      .wdata(req.wdata),
      .bus_mode(bus_ext_mode),
      .force_latch((p == LATCH_PORT) && pcr_q),
      .pin_sync(pin_sync[p*DATA_W +: DATA_W]),
      .dir_q(dir_all[p*DATA_W +: DATA_W]),
      .lat_q(lat_all[p*DATA_W +: DATA_W]),
      .rd_value(rd_all[p*DATA_W +: DATA_W])
    );
  end

  assign pull_we = req.wr && (req.page == PG_PULL);

  gpio_pullup #(
    .NUM_PORTS(NUM_PORTS),
    .NPU(NPU),
    .GATED_FROM(GATED_FROM),
    .BUS_MASK(BUS_MASK)
  ) i_pull (
    .clk(clk),
    .rst_ni(rst_ni),
    .we(pull_we),
    .idx(req.idx),
    .wdata(req.wdata),
    .bus_mode(bus_ext_mode),
    .dir_all(dir_all),
    .rd_value(pull_rd),
    .pin_pu(pin_pu)
  );

  assign pcr_we = req.wr && (req.page == PG_CTRL) && (req.idx == 4'd0);

  always_comb begin
    pcr_d = pcr_q;
    if (pcr_we) pcr_d = req.wdata[0];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) pcr_q <= 1'b0;
    else         pcr_q <= pcr_d;
  end

  always_comb begin
    sel_rd = '0;
    unique case (req.page)
      PG_DIR: begin
        for (int p = 0; p < NUM_PORTS; p++)
          if (req.idx == 4'(p)) sel_rd = dir_all[p*DATA_W +: DATA_W];
      end
      PG_DATA: begin
        for (int p = 0; p < NUM_PORTS; p++)
          if (req.idx == 4'(p)) sel_rd = rd_all[p*DATA_W +: DATA_W];
      end
      PG_PULL: sel_rd = pull_rd;
      PG_CTRL: if (req.idx == 4'd0) sel_rd = {{(DATA_W-1){1'b0}}, pcr_q};
      default: sel_rd = '0;
    endcase
  end

  assign bus_rdata = req.rd ? sel_rd : '0;
  assign pin_oe    = dir_all;
  assign pin_out   = lat_all & dir_all;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int                   NUM_PORTS  = 6,
  parameter logic [NUM_PORTS-1:0] BUS_MASK   = 6'b000111,
  parameter int                   NODIR_PORT = 4,
  parameter int                   NODIR_BIT  = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_sel,
  input logic                    bus_wr,
  input logic [7:0]              bus_addr,
  input logic [7:0]              bus_rdata,
  input logic                    bus_ext_mode,
  input logic [NUM_PORTS*8-1:0]  pin_oe,
  input logic [NUM_PORTS*8-1:0]  pin_out,
  input logic [NUM_PORTS*8-1:0]  pin_pu
);
  localparam int PW = NUM_PORTS * 8;

  logic [PW-1:0] shared_bits;
  for (genvar i = 0; i < PW; i++) begin : g_sh
    assign shared_bits[i] = BUS_MASK[i/8];
  end

  logic unmapped_rd;
  always_comb begin
    unmapped_rd = 1'b0;
    if (bus_sel && !bus_wr) begin
      if (bus_addr[7:4] > 4'h3) unmapped_rd = 1'b1;
      if (bus_addr[7:4] <= 4'h1 && int'(bus_addr[3:0]) >= NUM_PORTS) unmapped_rd = 1'b1;
      if (bus_addr[7:4] == 4'h3 && bus_addr[3:0] != 4'h0) unmapped_rd = 1'b1;
    end
  end

  // R5
  pu_input_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu & pin_oe) == '0);

  // R4
  out_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  // R8
  bus_pu_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ext_mode |-> ((pin_pu & shared_bits) == '0));

  // R7
  dir_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ext_mode && bus_sel && bus_wr) |=> $stable(pin_oe & shared_bits));

  // R10
  nodir_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 8'(NODIR_PORT)) |-> !bus_rdata[NODIR_BIT]);

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_rd |-> (bus_rdata == 8'h00));
endmodule

bind gpio_bank gpio_bank_chk #(
  .NUM_PORTS(NUM_PORTS),
  .BUS_MASK(BUS_MASK),
  .NODIR_PORT(NODIR_PORT),
  .NODIR_BIT(NODIR_BIT)
) i_chk (
  .clk(clk),
  .rst_n(rst_n),
  .bus_sel(bus_sel),
  .bus_wr(bus_wr),
  .bus_addr(bus_addr),
  .bus_rdata(bus_rdata),
  .bus_ext_mode(bus_ext_mode),
  .pin_oe(pin_oe),
  .pin_out(pin_out),
  .pin_pu(pin_pu)
);

// File: tb/test_gpio_bank.sv
`timescale 1ns/1ps
module test_gpio_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00, bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        bus_ext_mode = 1'b0;
  logic [47:0] pin_in = '0;
  logic [47:0] pin_oe, pin_out, pin_pu;

  integer checks = 0, errors = 0;
  bit     done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_bank i_gpio_bank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ext_mode(bus_ext_mode), .pin_in(pin_in), .pin_oe(pin_oe),
    .pin_out(pin_out), .pin_pu(pin_pu)
  );

  // ---------------- behavioural reference model ----------------
  logic        mr1, mr2;
  logic [7:0]  mdir [6];
  logic [7:0]  mlat [6];
  logic [11:0] mnib;
  logic        mglob, mpcr;
  logic [47:0] ms1, ms2;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin mr1 <= 1'b0; mr2 <= 1'b0; end
    else begin mr1 <= 1'b1; mr2 <= mr1; end

  function automatic bit shared(input int p);
    return p <= 2;
  endfunction

  always @(posedge clk or negedge mr2) begin
    if (!mr2) begin
      for (int p = 0; p < 6; p++) begin mdir[p] <= 8'h00; mlat[p] <= 8'h00; end
      mnib <= '0; mglob <= 1'b0; mpcr <= 1'b0; ms1 <= '0; ms2 <= '0;
    end else begin
      ms1 <= pin_in;
      ms2 <= ms1;
      if (bus_sel && bus_wr) begin
        int pg, ix;
        pg = int'(bus_addr[7:4]);
        ix = int'(bus_addr[3:0]);
        if (pg == 0 && ix < 6 && !(bus_ext_mode && shared(ix)))
          mdir[ix] <= bus_wdata & ((ix == 4) ? 8'hDF : 8'hFF);
        if (pg == 1 && ix < 6) mlat[ix] <= bus_wdata;
        if (pg == 2 && ix == 0) mnib[7:0] <= bus_wdata;
        if (pg == 2 && ix == 1) begin mnib[11:8] <= bus_wdata[3:0]; mglob <= bus_wdata[7]; end
        if (pg == 3 && ix == 0) mpcr <= bus_wdata[0];
      end
    end
  end

  function automatic logic [7:0] m_rd();
    int pg, ix;
    logic [7:0] sel;
    if (!(bus_sel && !bus_wr)) return 8'h00;
    pg = int'(bus_addr[7:4]);
    ix = int'(bus_addr[3:0]);
    if (pg == 0 && ix < 6) return mdir[ix];
    if (pg == 1 && ix < 6) begin
      sel = mdir[ix] | ((ix == 1 && mpcr) ? 8'hFF : 8'h00);
      return (mlat[ix] & sel) | (ms2[ix*8 +: 8] & ~sel);
    end
    if (pg == 2 && ix == 0) return mnib[7:0];
    if (pg == 2 && ix == 1) return {mglob, 3'b000, mnib[11:8]};
    if (pg == 3 && ix == 0) return {7'd0, mpcr};
    return 8'h00;
  endfunction

  function automatic logic [47:0] m_oe();
    for (int p = 0; p < 6; p++) m_oe[p*8 +: 8] = mdir[p];
  endfunction

  function automatic logic [47:0] m_out();
    for (int p = 0; p < 6; p++) m_out[p*8 +: 8] = mlat[p] & mdir[p];
  endfunction

  function automatic logic [47:0] m_pu();
    for (int i = 0; i < 48; i++) begin
      int p;
      p = i / 8;
      m_pu[i] = mnib[i/4] && !(bus_ext_mode && shared(p)) &&
                (p < 5 || mglob) && !mdir[p][i%8];
    end
  endfunction

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    #1;
    if (mr2 && !done) begin
      chk("R2 model pin_oe", pin_oe, m_oe());
      chk("R4 model pin_out", pin_out, m_out());
      chk("R5 model pin_pu", pin_pu, m_pu());
      chk("R3 model bus_rdata", {40'd0, bus_rdata}, {40'd0, m_rd()});
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2;
    chk(tag, {40'd0, bus_rdata}, {40'd0, exp});
    bus_sel = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1: reset state
    chk("R1 pin_oe", pin_oe, '0);
    chk("R1 pin_pu", pin_pu, '0);
    chk("R1 pin_out", pin_out, '0);
    for (int p = 0; p < 6; p++) rd(8'(p), 8'h00, "R1 dir");
    rd(8'h20, 8'h00, "R1 pull0");
    rd(8'h21, 8'h00, "R1 pull1");
    rd(8'h30, 8'h00, "R1 ctrl");

    // R2, R3, R4: mixed direction port 3
    wr(8'h03, 8'hF0);
    wr(8'h13, 8'hA5);
    pin_in[31:24] = 8'h3C;
    idle(3);
    rd(8'h03, 8'hF0, "R2 dir readback");
    chk("R2 pin_oe port3", {40'd0, pin_oe[31:24]}, {40'd0, 8'hF0});
    chk("R4 pin_out port3", {40'd0, pin_out[31:24]}, {40'd0, 8'hA0});
    rd(8'h13, 8'hAC, "R3 mixed read");

    // R4: latch write while input
    wr(8'h12, 8'h5A);
    chk("R4 input no drive", {40'd0, pin_out[23:16]}, 48'd0);
    rd(8'h12, 8'h00, "R3 input read pin");
    wr(8'h02, 8'hFF);
    chk("R4 latch appears", {40'd0, pin_out[23:16]}, {40'd0, 8'h5A});
    rd(8'h12, 8'h5A, "R3 output read latch");

    // R5: nibble pull-ups, input only
    wr(8'h01, 8'h03);
    wr(8'h20, 8'h05);
    chk("R5 port0 pu", {40'd0, pin_pu[7:0]}, {40'd0, 8'h0F});
    chk("R5 port1 pu", {40'd0, pin_pu[15:8]}, {40'd0, 8'h0C});

    // R6: gated top port
    wr(8'h21, 8'h04);
    chk("R6 gated off", {40'd0, pin_pu[47:40]}, 48'd0);
    wr(8'h21, 8'h84);
    chk("R6 gated on", {40'd0, pin_pu[47:40]}, {40'd0, 8'h0F});
    rd(8'h21, 8'h84, "R6 readback");

    // R7, R8: bus mode
    @(negedge clk); bus_ext_mode = 1'b1;
    #2;
    chk("R8 shared pu off", {24'd0, pin_pu[23:0]}, 48'd0);
    chk("R8 other pu kept", {40'd0, pin_pu[47:40]}, {40'd0, 8'h0F});
    rd(8'h20, 8'h05, "R8 readback");
    wr(8'h20, 8'h30);
    rd(8'h20, 8'h30, "R8 write accepted");
    wr(8'h01, 8'hFF);
    rd(8'h01, 8'h03, "R7 dir locked");
    chk("R7 pin_oe port1", {40'd0, pin_oe[15:8]}, {40'd0, 8'h03});
    wr(8'h04, 8'hFF);
    rd(8'h04, 8'hDF, "R7 R10 unshared dir");
    chk("R10 pin_oe hole", {47'd0, pin_oe[37]}, 48'd0);
    @(negedge clk); bus_ext_mode = 1'b0;
    #2;
    chk("R5 outputs no pu", {40'd0, pin_pu[23:16]}, 48'd0);
    wr(8'h02, 8'h0F);
    chk("R5 port2 upper pu", {40'd0, pin_pu[23:16]}, {40'd0, 8'hF0});

    // R9: latch-read control
    wr(8'h11, 8'h69);
    pin_in[15:8] = 8'hF0;
    idle(3);
    rd(8'h11, 8'hF1, "R3 port1 normal");
    wr(8'h30, 8'h01);
    rd(8'h30, 8'h01, "R9 ctrl readback");
    rd(8'h11, 8'h69, "R9 forced latch");
    rd(8'h13, 8'hAC, "R9 other port");
    wr(8'h30, 8'h00);
    rd(8'h11, 8'hF1, "R9 cleared");

    // R11: unmapped
    rd(8'h06, 8'h00, "R11 dir gap");
    rd(8'h16, 8'h00, "R11 data gap");
    rd(8'h22, 8'h00, "R11 pull gap");
    rd(8'h31, 8'h00, "R11 ctrl gap");
    rd(8'h40, 8'h00, "R11 page gap");
    rd(8'hFF, 8'h00, "R11 top");
    wr(8'h06, 8'hFF);
    wr(8'h22, 8'hFF);
    rd(8'h05, 8'h00, "R11 no side effect dir");
    rd(8'h21, 8'h84, "R11 no side effect pull");

    idle(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule